// File: doc/BRIEF.md
# Fractional-Divider I2S Stereo Serializer

This block turns one signed 16-bit mono sample per frame into a standard I2S stream carrying the same value in both the left and the right slot, each slot 16 bits wide. It runs entirely on the 24 MHz system clock: the bit clock, the word-select line and the data line are ordinary registered or decoded outputs, and no divided clock is ever created.

Because 24 MHz is not an integer multiple of the 1.536 MHz bit rate (the ratio is 15.625), the length of each bit period is taken from a repeating eight-entry table of 16 and 15 clocks. Eight bits take exactly 125 clocks, so a 32-bit frame takes exactly 500 clocks and the frame rate is exactly 48 kHz. A 0..31 bit counter is the single source of the word-select level, the frame boundary and the moment a new sample is taken. A one-clock frame-start strobe tells the sample producer that the value it presented has just been captured.

Top module: `i2s_frac_serializer`

## Requirements
- R1: After reset the bit clock, word select, serial data and frame-start strobe are all low, and the first frame carries an all-zero sample in every slot whatever the sample input holds.
- R2: Bit periods follow the repeating system-clock sequence 16, 16, 15, 16, 16, 15, 16, 15, and slot 0 of every frame uses the first entry of that sequence.
- R3: Within each bit period the bit clock is low for the first half of the period rounded down (8 clocks of 16, 7 clocks of 15) and high for the remaining clocks.
- R4: A frame is 32 bit slots (numbered 0 to 31) lasting exactly 500 system clocks; the frame-start strobe is high for exactly the first clock of slot 0 of each frame that follows a slot-31-to-slot-0 wrap, and does not pulse for the frame that starts at reset.
- R5: Word select is low during slots 0 to 15 and high during slots 16 to 31, so it changes one slot before the most significant bit of each channel.
- R6: The sample input is captured only at the clock edge that ends slot 31 (the edge on which the strobe rises); changes at any other time have no effect on the frame being sent.
- R7: The captured sample is sent most significant bit first: bit 15 down to bit 0 in slots 1 to 16 (left channel), bit 15 down to bit 1 in slots 17 to 31 and bit 0 in slot 0 of the following frame (right channel).
- R8: Serial data changes only on a falling edge of the bit clock, i.e. at the start of a bit period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 24 MHz system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_i | input | 16 | Signed mono sample, captured once per frame |
| bclk_o | output | 1 | Serial bit clock, averaging 1.536 MHz |
| lrclk_o | output | 1 | Word select: low for left, high for right |
| sdata_o | output | 1 | Serial data, MSB first |
| frame_start_o | output | 1 | One-clock strobe at the first clock of slot 0 |

## Verification
The bench measures every bit period and its low phase from bit-clock edges, so a table read off by one index, a short interval placed in the wrong position, or a low phase rounded up would show as a wrong count in a specific slot. It counts clocks between strobes, catching a divider that drifts away from 500 clocks per frame or a strobe that fires at reset. Frames are rebuilt from data sampled on rising bit-clock edges and compared slot by slot, which exposes word select changing on the MSB instead of one slot earlier, a right channel that is not a copy of the left, LSB-first order, and a sample taken mid-frame instead of at the wrap. A running monitor flags any data change that does not coincide with a falling bit clock.

// File: rtl/i2s_frac_pkg.sv
package i2s_frac_pkg;

   // Length in system clocks of one bit period for a given table entry.
   function automatic int period_len(input int long_len, input bit is_short);
      return long_len - (is_short ? 1 : 0);
   endfunction

   // Clocks spent high within a period: the low phase is the half rounded down.
   function automatic int high_len(input int len);
      return len - len / 2;
   endfunction

endpackage

// File: rtl/i2s_bit_timer.sv
module i2s_bit_timer
   import i2s_frac_pkg::*;
#(
   parameter int          CLK_LONG   = 16,
   parameter int          PAT_LEN    = 8,
   parameter logic [31:0] SHORT_MASK = 32'h0000_00A4
) (
   input  logic clk,
   input  logic rst_n,
   output logic bclk_o,
   output logic bit_end_o
);
   localparam int CNT_W  = $clog2(CLK_LONG);
   localparam int PIDX_W = (PAT_LEN > 1) ? $clog2(PAT_LEN) : 1;

   logic [CNT_W-1:0]  last_tab [PAT_LEN];
   logic [CNT_W-1:0]  hi_tab   [PAT_LEN];
   logic [CNT_W-1:0]  cnt_q;
   logic [PIDX_W-1:0] pidx_q;
   logic [PIDX_W-1:0] pidx_nxt;

   // Per-entry countdown start value and high-phase length.
   for (genvar i = 0; i < PAT_LEN; i++) begin : g_tab
      localparam int LEN = period_len(CLK_LONG, SHORT_MASK[i]);
      assign last_tab[i] = CNT_W'(LEN - 1);
      assign hi_tab[i]   = CNT_W'(high_len(LEN));
   end

   assign pidx_nxt  = pidx_q + 1'b1;
   assign bit_end_o = (cnt_q == '0);
   assign bclk_o    = (cnt_q < hi_tab[pidx_q]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= last_tab[0];
         pidx_q <= '0;
      end else if (bit_end_o) begin
         cnt_q  <= last_tab[pidx_nxt];
         pidx_q <= pidx_nxt;
      end else begin
         cnt_q  <= cnt_q - 1'b1;
      end
   end

   // R2: the table index moves only when a bit period ends.
   a_r2_index_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !bit_end_o |=> $stable(pidx_q));
   // R3: the last clock of a period is high, the first clock of the next is low.
   a_r3_high_at_end: assert property (@(posedge clk) disable iff (!rst_n)
      bit_end_o |-> bclk_o);
   a_r3_low_at_start: assert property (@(posedge clk) disable iff (!rst_n)
      bit_end_o |=> !bclk_o);
endmodule

// File: rtl/i2s_slot_counter.sv
module i2s_slot_counter #(
   parameter int SLOT_W = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bit_end_i,
   output logic lrclk_o,
   output logic wrap_o,
   output logic load_o,
   output logic frame_start_o
);
   localparam int BITS  = 2 * SLOT_W;
   localparam int BIT_W = $clog2(BITS);

   logic [BIT_W-1:0] bit_q;
   logic             fs_q;

   assign wrap_o        = bit_end_i && (bit_q == BIT_W'(BITS - 1));
   assign load_o        = bit_end_i && (bit_q == '0);
   assign lrclk_o       = bit_q[BIT_W-1];
   assign frame_start_o = fs_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_q <= '0;
         fs_q  <= 1'b0;
      end else begin
         fs_q <= wrap_o;
         if (bit_end_i) bit_q <= bit_q + 1'b1;
      end
   end

   // R4: the strobe only ever marks slot 0.
   a_r4_strobe_slot0: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start_o |-> (bit_q == '0));
   // R5: word select never moves inside a bit period.
   a_r5_lr_stable: assert property (@(posedge clk) disable iff (!rst_n)
      !bit_end_i |=> $stable(lrclk_o));
endmodule

// File: rtl/i2s_data_shifter.sv
module i2s_data_shifter #(
   parameter int SLOT_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [SLOT_W-1:0] sample_i,
   input  logic              bit_end_i,
   input  logic              wrap_i,
   input  logic              load_i,
   output logic              sdata_o
);
   logic [SLOT_W-1:0]   hold_q;
   logic [2*SLOT_W-1:0] sh_q;

   assign sdata_o = sh_q[2*SLOT_W-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q <= '0;
         sh_q   <= '0;
      end else begin
         if (wrap_i) hold_q <= sample_i;
         if (load_i)         sh_q <= {hold_q, hold_q};
         else if (bit_end_i) sh_q <= {sh_q[2*SLOT_W-2:0], 1'b0};
      end
   end

   // R6: the captured sample changes only at the frame wrap.
   a_r6_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
      !wrap_i |=> $stable(hold_q));
   // R8: serial data moves only where a bit period starts.
   a_r8_data_on_boundary: assert property (@(posedge clk) disable iff (!rst_n)
      !bit_end_i |=> $stable(sdata_o));
endmodule

// File: rtl/i2s_frac_serializer.sv
module i2s_frac_serializer #(
   parameter int          CLK_LONG   = 16,
   parameter int          PAT_LEN    = 8,
   parameter logic [31:0] SHORT_MASK = 32'h0000_00A4,
   parameter int          SLOT_W     = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [SLOT_W-1:0] sample_i,
   output logic              bclk_o,
   output logic              lrclk_o,
   output logic              sdata_o,
   output logic              frame_start_o
);
   // Elaboration-time parameter checks.
   if (CLK_LONG < 4) begin : g_bad_long
      $error("CLK_LONG must be at least 4");
   end
   if ((PAT_LEN < 1) || (PAT_LEN > 32) || ((PAT_LEN & (PAT_LEN - 1)) != 0)) begin : g_bad_pat
      $error("PAT_LEN must be a power of two between 1 and 32");
   end
   if (((2 * SLOT_W) % PAT_LEN) != 0) begin : g_bad_align
      $error("a frame must hold a whole number of interval patterns");
   end
   if ((SLOT_W < 2) || ((SLOT_W & (SLOT_W - 1)) != 0)) begin : g_bad_slot
      $error("SLOT_W must be a power of two");
   end

   logic bit_end, wrap, load;

   i2s_bit_timer #(
      .CLK_LONG  (CLK_LONG),
      .PAT_LEN   (PAT_LEN),
      .SHORT_MASK(SHORT_MASK)
   ) timer_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .bclk_o   (bclk_o),
      .bit_end_o(bit_end)
   );

   i2s_slot_counter #(.SLOT_W(SLOT_W)) slots_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .bit_end_i    (bit_end),
      .lrclk_o      (lrclk_o),
      .wrap_o       (wrap),
      .load_o       (load),
      .frame_start_o(frame_start_o)
   );

   i2s_data_shifter #(.SLOT_W(SLOT_W)) data_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .sample_i (sample_i),
      .bit_end_i(bit_end),
      .wrap_i   (wrap),
      .load_i   (load),
      .sdata_o  (sdata_o)
   );
endmodule

// File: tb/i2s_frac_serializer_tb.sv
module i2s_frac_serializer_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] sample = 16'h0000;
   logic        bclk, lrclk, sdata, fs;

   int n_chk = 0;
   int n_bad = 0;
   logic [15:0] prev_s;

   always #10 clk = ~clk;

   i2s_frac_serializer dut_i (
      .clk(clk), .rst_n(rst_n), .sample_i(sample),
      .bclk_o(bclk), .lrclk_o(lrclk), .sdata_o(sdata), .frame_start_o(fs)
   );

   task automatic check(input string req, input int act, input int exp, input string what);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // R8 monitor: any data change must coincide with a falling bit clock.
   logic p_bclk, p_sdata;
   int   r8_bad = 0;
   always @(negedge clk) begin
      if (rst_n && (sdata !== p_sdata) && !(p_bclk && !bclk)) r8_bad++;
      p_bclk  = bclk;
      p_sdata = sdata;
   end

   task automatic wait_fs();
      do @(negedge clk); while (!fs);
   endtask

   // Starting at the first clock of slot 0, record data and word select at
   // each of the 32 rising bit-clock edges.
   task automatic grab(output logic [31:0] bits, output logic [31:0] lr);
      logic pb;
      int   k;
      pb = bclk;
      k  = 0;
      while (k < 32) begin
         @(negedge clk);
         if (!pb && bclk) begin
            bits[k] = sdata;
            lr[k]   = lrclk;
            k++;
         end
         pb = bclk;
      end
   endtask

   task automatic check_frame(input string req, input logic [15:0] s, input logic [15:0] last,
                              input logic [31:0] bits, input logic [31:0] lr);
      for (int b = 0; b < 32; b++) begin
         logic e;
         if (b == 0)       e = last[0];
         else if (b <= 16) e = s[16 - b];
         else              e = s[32 - b];
         check(req, int'(bits[b]), int'(e), $sformatf("data slot %0d", b));
         check("R5", int'(lr[b]), (b >= 16) ? 1 : 0, $sformatf("word select slot %0d", b));
      end
   endtask

   task automatic test_reset();
      logic [31:0] bits, lr;
      sample = 16'h1234;
      rst_n  = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      check("R1", int'(bclk),  0, "bclk after reset");
      check("R1", int'(lrclk), 0, "lrclk after reset");
      check("R1", int'(sdata), 0, "sdata after reset");
      check("R1", int'(fs),    0, "strobe after reset");
      grab(bits, lr);
      check_frame("R1", 16'h0000, 16'h0000, bits, lr);
      prev_s = 16'h0000;
   endtask

   task automatic test_data(input logic [15:0] s);
      logic [31:0] bits, lr;
      sample = s;
      wait_fs();
      grab(bits, lr);
      check_frame("R7", s, prev_s, bits, lr);
      prev_s = s;
   endtask

   task automatic test_ignore(input logic [15:0] s, input logic [15:0] late);
      logic [31:0] bits, lr;
      sample = s;
      wait_fs();
      sample = late;          // arrives after the capture edge
      grab(bits, lr);
      check_frame("R6", s, prev_s, bits, lr);
      prev_s = s;
      sample = 16'h0F0F;      // still mid-frame: must not be the one captured
      repeat (5) @(negedge clk);
      sample = late;
      wait_fs();
      grab(bits, lr);
      check_frame("R6", late, prev_s, bits, lr);
      prev_s = late;
   endtask

   task automatic test_intervals();
      int exp_len[8] = '{16, 16, 15, 16, 16, 15, 16, 15};
      int len, low, pb, k;
      wait_fs();
      len = 1; low = (bclk == 1'b0) ? 1 : 0; pb = bclk; k = 0;
      while (k < 16) begin
         @(negedge clk);
         if (pb && !bclk) begin
            check("R2", len, exp_len[k % 8], $sformatf("period of slot %0d", k));
            check("R3", low, exp_len[k % 8] / 2, $sformatf("low phase of slot %0d", k));
            k++;
            len = 0; low = 0;
         end
         len++;
         if (!bclk) low++;
         pb = bclk;
      end
   endtask

   task automatic test_frame_len();
      int n;
      wait_fs();
      n = 0;
      do begin @(negedge clk); n++; end while (!fs);
      check("R4", n, 500, "clocks between strobes");
      @(negedge clk);
      check("R4", int'(fs), 0, "strobe width");
   endtask

   initial begin : wd
      repeat (200000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      p_bclk = 1'b0; p_sdata = 1'b0;
      test_reset();
      test_data(16'h1234);
      test_data(16'h8001);
      test_data(16'h7FFE);
      test_data(16'hA5C3);
      test_data(16'hFFFF);
      test_ignore(16'h3C96, 16'hC3A5);
      test_intervals();
      test_frame_len();
      test_frame_len();
      check("R8", r8_bad, 0, "data changes off a falling bit clock");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule